// File: doc/BRIEF.md
# Compare Timer Frame with Auto-Increment

The block is one timer frame sitting on a 32-bit register bus. It watches a free-running 64-bit system count and compares it against a programmable 64-bit compare value. When the frame is enabled and the count has reached the compare value, the frame reports a firing status and can raise its interrupt line. Software arms a one-shot event by writing the current count plus a delta into the compare value and then enabling the frame with the interrupt unmasked.

An optional auto-increment mode makes the frame periodic. Each time the count reaches the compare value, hardware adds a reload interval to the compare value and sets a sticky event flag. The interrupt then follows that flag until software clears it, so software never has to rewrite the compare value. A configuration register reports whether the auto-increment hardware is present.

Reads return data one cycle after the read strobe. Writes take effect at the clock edge that samples the write strobe.

Top module: `cmp_timer_frame`

## Requirements
- R1: A read of offset 0x00 returns count bits [31:0] and a read of offset 0x04 returns count bits [63:32]. Read data appears on the cycle after the read strobe and holds until the next read.
- R2: The compare value is written as two 32-bit halves, with the low half at 0x20 and the high half at 0x24. Both halves read back what was written.
- R3: The control register at 0x2C holds enable in bit 0 and the interrupt mask in bit 1. Bit 2 is the firing status and is read-only, so writing it has no effect. Unused bits read zero.
- R4: The status bit reads 1 exactly when enable is set and the count is greater than or equal to the compare value. The mask setting does not affect it.
- R5: With auto-increment off, the interrupt output equals enable AND status AND NOT mask.
- R6: With enable and auto-increment on (bit 0 of 0x4C), a cycle in which the count is greater than or equal to the compare value adds the reload interval (0x48) to the compare value at the next edge and sets the event flag (bit 1 of 0x4C). A software write to a compare half in that cycle takes precedence over the increment.
- R7: Writing 0 to bit 1 of 0x4C clears the event flag and writing 1 leaves it unchanged. When a hardware set and a software clear fall in the same cycle, the flag ends up set.
- R8: With auto-increment on, the interrupt output equals enable AND NOT mask AND event flag.
- R9: Bits [3:0] of the configuration register at 0x50 read 1 when auto-increment is built in and 0 when it is not. All other bits read zero.
- R10: After reset, compare, reload, control and auto-increment state are zero and the interrupt is low. Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe |
| busAddr | input | 8 | Byte offset of the access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| countIn | input | 64 | Free-running system count |
| irqOut | output | 1 | Interrupt request |

## Verification
The hardest situation to create is the one where the hardware sets the event flag and a software clear arrives in the same cycle. The bench produces it by changing the count input to equal the advanced compare value on the same falling edge on which it drives the write that clears the flag. It then reads back the flag and the compare value. The bench holds the count input at fixed values between steps, which makes the point of each firing and each advance of the compare value exact. This lets the bench predict each readback and each interrupt level from the requirements alone.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  localparam int CNT_W  = 64;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_CNT_LO = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CNT_HI = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_CMP_LO = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_CMP_HI = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_CTL    = 8'h2C;
  localparam logic [ADDR_W-1:0] OFS_RELOAD = 8'h48;
  localparam logic [ADDR_W-1:0] OFS_AUTO   = 8'h4C;
  localparam logic [ADDR_W-1:0] OFS_CFG    = 8'h50;

  // write strobes from control to datapath
  typedef struct packed {
    logic              wrCmpLo;
    logic              wrCmpHi;
    logic              wrCtl;
    logic              wrReload;
    logic              wrAuto;
    logic [DATA_W-1:0] wdata;
  } frame_strobe_t;

  // datapath state seen by control and checker
  typedef struct packed {
    logic [CNT_W-1:0]  cmpVal;
    logic [DATA_W-1:0] reload;
    logic              ctlEn;
    logic              ctlMask;
    logic              status;
    logic              autoEn;
    logic              evtFlag;
  } frame_state_t;
endpackage

// File: rtl/cmp_timer_ctrl.sv
module cmp_timer_ctrl
  import cmp_timer_pkg::*;
#(
  parameter bit AUTO_IMPL = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [CNT_W-1:0]  countIn,
  input  frame_state_t      st,
  output frame_strobe_t     stb,
  output logic [DATA_W-1:0] busRdata
);
  localparam int HALF = DATA_W;
  localparam logic [3:0] CFG_CODE = AUTO_IMPL ? 4'd1 : 4'd0;

  logic [DATA_W-1:0] rdMux;

  always_comb begin
    stb          = '0;
    stb.wdata    = busWdata;
    stb.wrCmpLo  = busWr && (busAddr == OFS_CMP_LO);
    stb.wrCmpHi  = busWr && (busAddr == OFS_CMP_HI);
    stb.wrCtl    = busWr && (busAddr == OFS_CTL);
    stb.wrReload = busWr && (busAddr == OFS_RELOAD);
    stb.wrAuto   = busWr && (busAddr == OFS_AUTO);
  end

  always_comb begin
    rdMux = '0;
    case (busAddr)
      OFS_CNT_LO: rdMux = countIn[HALF-1:0];
      OFS_CNT_HI: rdMux = countIn[CNT_W-1:HALF];
      OFS_CMP_LO: rdMux = st.cmpVal[HALF-1:0];
      OFS_CMP_HI: rdMux = st.cmpVal[CNT_W-1:HALF];
      OFS_CTL:    rdMux = {{(DATA_W-3){1'b0}}, st.status, st.ctlMask, st.ctlEn};
      OFS_RELOAD: rdMux = st.reload;
      OFS_AUTO:   rdMux = {{(DATA_W-2){1'b0}}, st.evtFlag, st.autoEn};
      OFS_CFG:    rdMux = {{(DATA_W-4){1'b0}}, CFG_CODE};
      default:    rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      busRdata <= '0;
    else if (busRd) busRdata <= rdMux;
  end
endmodule

// File: rtl/cmp_timer_dp.sv
module cmp_timer_dp
  import cmp_timer_pkg::*;
#(
  parameter bit AUTO_IMPL = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  frame_strobe_t    stb,
  input  logic [CNT_W-1:0] countIn,
  output frame_state_t     st,
  output logic             irqOut
);
  localparam int HALF = DATA_W;
  localparam int PAD  = CNT_W - DATA_W;

  logic [CNT_W-1:0]  cmpVal, cmpNext;
  logic [DATA_W-1:0] reload;
  logic              ctlEn, ctlMask;
  logic              autoEn, evtFlag;
  logic              reached, fire;

  assign reached = countIn >= cmpVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlEn   <= 1'b0;
      ctlMask <= 1'b0;
    end else if (stb.wrCtl) begin
      ctlEn   <= stb.wdata[0];
      ctlMask <= stb.wdata[1];
    end
  end

  generate
    if (AUTO_IMPL) begin : g_auto
      assign fire = ctlEn && autoEn && reached;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          reload  <= '0;
          autoEn  <= 1'b0;
          evtFlag <= 1'b0;
        end else begin
          if (stb.wrReload) reload <= stb.wdata;
          if (stb.wrAuto) begin
            autoEn  <= stb.wdata[0];
            evtFlag <= evtFlag && stb.wdata[1];
          end
          if (fire) evtFlag <= 1'b1;
        end
      end
    end else begin : g_noauto
      assign fire    = 1'b0;
      assign reload  = '0;
      assign autoEn  = 1'b0;
      assign evtFlag = 1'b0;
    end
  endgenerate

  always_comb begin
    cmpNext = cmpVal;
    if (stb.wrCmpLo || stb.wrCmpHi) begin
      if (stb.wrCmpLo) cmpNext[HALF-1:0]     = stb.wdata;
      if (stb.wrCmpHi) cmpNext[CNT_W-1:HALF] = stb.wdata;
    end else if (fire) begin
      cmpNext = cmpVal + {{PAD{1'b0}}, reload};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cmpVal <= '0;
    else       cmpVal <= cmpNext;
  end

  always_comb begin
    st         = '0;
    st.cmpVal  = cmpVal;
    st.reload  = reload;
    st.ctlEn   = ctlEn;
    st.ctlMask = ctlMask;
    st.status  = ctlEn && reached;
    st.autoEn  = autoEn;
    st.evtFlag = evtFlag;
  end

  assign irqOut = ctlEn && !ctlMask && (autoEn ? evtFlag : reached);
endmodule

// File: rtl/cmp_timer_frame.sv
module cmp_timer_frame
  import cmp_timer_pkg::*;
#(
  parameter bit AUTO_IMPL = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [CNT_W-1:0]  countIn,
  output logic              irqOut
);
  frame_strobe_t stb;
  frame_state_t  st;

  cmp_timer_ctrl #(.AUTO_IMPL(AUTO_IMPL)) ctrlI (
    .clk(clk), .rstN(rstN), .busRd(busRd), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .countIn(countIn),
    .st(st), .stb(stb), .busRdata(busRdata)
  );

  cmp_timer_dp #(.AUTO_IMPL(AUTO_IMPL)) dpI (
    .clk(clk), .rstN(rstN), .stb(stb), .countIn(countIn),
    .st(st), .irqOut(irqOut)
  );
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk
  import cmp_timer_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busRd,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic [CNT_W-1:0]  countIn,
  input logic              irqOut,
  input frame_state_t      st
);
  logic cmpWrite, flagClear, autoFire;
  assign cmpWrite  = busWr && (busAddr == OFS_CMP_LO || busAddr == OFS_CMP_HI);
  assign flagClear = busWr && (busAddr == OFS_AUTO) && !busWdata[1];
  assign autoFire  = st.ctlEn && st.autoEn && (countIn >= st.cmpVal);

  // R5 / R8: a disabled or masked frame never interrupts
  p_irq_gate_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!st.ctlEn || st.ctlMask) |-> !irqOut);

  // R5: plain compare mode drives the interrupt when reached
  p_plain_irq_r5: assert property (@(posedge clk) disable iff (!rstN)
    (st.ctlEn && !st.ctlMask && !st.autoEn && countIn >= st.cmpVal) |-> irqOut);

  // R6: an expiry advances the compare value by the reload
  p_advance_r6: assert property (@(posedge clk) disable iff (!rstN)
    (autoFire && !cmpWrite) |=> (st.cmpVal == $past(st.cmpVal) + {{(CNT_W-DATA_W){1'b0}}, $past(st.reload)}));

  // R6: an expiry sets the event flag
  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    autoFire |=> st.evtFlag);

  // R7: only a zero write clears the flag
  p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (st.evtFlag && !flagClear) |=> st.evtFlag);

  // R8: in auto mode the interrupt follows the flag
  p_auto_irq_r8: assert property (@(posedge clk) disable iff (!rstN)
    (st.autoEn && st.ctlEn && !st.ctlMask) |-> (irqOut == st.evtFlag));

  // R10: unmapped offset reads zero
  p_unmapped_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == 8'h10) |=> (busRdata == '0));

  // R1: read data holds between reads
  p_rdata_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |=> $stable(busRdata));
endmodule

bind cmp_timer_frame cmp_timer_chk chkI (.*);

// File: tb/cmp_timer_frame_tb.sv
module cmp_timer_frame_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busRd = 1'b0;
  logic        busWr = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [63:0] countIn = '0;
  logic        irqOut;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  logic [31:0] expQ[$];
  string       tagQ[$];

  always #2.5 clk = ~clk;

  cmp_timer_frame dut_i (
    .clk(clk), .rstN(rstN), .busRd(busRd), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .countIn(countIn), .irqOut(irqOut)
  );

  // monitor: read data is valid just after the edge that samples busRd
  always @(posedge clk) begin
    if (rstN && busRd) begin
      #1;
      if (expQ.size() > 0) begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        compared++;
        if (busRdata !== e) begin
          mismatched++;
          $display("FAIL %s: read got %08h expected %08h", t, busRdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    busRd = 1'b1; busAddr = a;
    expQ.push_back(e); tagQ.push_back(t);
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic chkIrq(input logic e, input string t);
    @(negedge clk);
    compared++;
    if (irqOut !== e) begin
      mismatched++;
      $display("FAIL %s: irq got %0b expected %0b", t, irqOut, e);
    end
  endtask

  initial begin
    #(5 * 20000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: run hung");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R10 reset state and unmapped read
    chkIrq(1'b0, "R10 reset irq");
    rd(8'h2C, 32'h0, "R10 reset ctl");
    rd(8'h20, 32'h0, "R10 reset cmp");
    rd(8'h4C, 32'h0, "R10 reset auto");
    rd(8'h48, 32'h0, "R10 reset reload");
    rd(8'h10, 32'h0, "R10 unmapped");
    rd(8'h50, 32'h1, "R9 config");
    // R1 count readback
    countIn = 64'h0000_0012_3456_789A;
    rd(8'h00, 32'h3456_789A, "R1 count lo");
    rd(8'h04, 32'h0000_0012, "R1 count hi");
    // R2 compare halves
    wr(8'h24, 32'hDEAD_0001);
    rd(8'h24, 32'hDEAD_0001, "R2 cmp hi");
    wr(8'h24, 32'h0);
    wr(8'h20, 32'h100);
    rd(8'h20, 32'h100, "R2 cmp lo");
    rd(8'h24, 32'h0, "R2 cmp hi cleared");
    // R3 status bit write ignored
    countIn = 64'h50;
    wr(8'h2C, 32'h5);
    rd(8'h2C, 32'h1, "R3 status write ignored");
    chkIrq(1'b0, "R5 below compare");
    // R4 / R5 reaching compare
    countIn = 64'h100;
    rd(8'h2C, 32'h5, "R4 status at equal");
    chkIrq(1'b1, "R5 fired");
    wr(8'h2C, 32'h3);
    rd(8'h2C, 32'h7, "R4 status with mask");
    chkIrq(1'b0, "R5 masked");
    countIn = 64'hFF;
    rd(8'h2C, 32'h3, "R4 status below");
    countIn = 64'h200;
    wr(8'h2C, 32'h2);
    rd(8'h2C, 32'h2, "R4 status disabled");
    chkIrq(1'b0, "R5 disabled");
    // R6 auto-increment
    wr(8'h2C, 32'h0);
    wr(8'h20, 32'h200);
    wr(8'h48, 32'h40);
    rd(8'h48, 32'h40, "R6 reload readback");
    wr(8'h4C, 32'h1);
    countIn = 64'h100;
    wr(8'h2C, 32'h1);
    chkIrq(1'b0, "R8 before expiry");
    @(negedge clk);
    countIn = 64'h200;
    @(negedge clk);
    chkIrq(1'b1, "R8 flag drives irq");
    rd(8'h20, 32'h240, "R6 cmp advanced");
    rd(8'h4C, 32'h3, "R6 flag set");
    rd(8'h2C, 32'h1, "R4 status after advance");
    // R7 flag clear rules
    wr(8'h4C, 32'h3);
    rd(8'h4C, 32'h3, "R7 write one keeps flag");
    wr(8'h4C, 32'h1);
    rd(8'h4C, 32'h1, "R7 write zero clears");
    chkIrq(1'b0, "R8 cleared flag");
    // R7 set beats clear in same cycle
    @(negedge clk);
    countIn = 64'h240;
    busWr = 1'b1; busAddr = 8'h4C; busWdata = 32'h1;
    @(negedge clk);
    busWr = 1'b0;
    rd(8'h4C, 32'h3, "R7 set beats clear");
    rd(8'h20, 32'h280, "R6 second advance");
    chkIrq(1'b1, "R8 irq after collision");
    wr(8'h2C, 32'h3);
    chkIrq(1'b0, "R8 masked auto");
    rd(8'h2C, 32'h3, "R3 ctl readback");
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule